// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor Table

This block sits beside the fetch stage of a pipelined core. It guesses the direction of conditional branches. Part of each fetch address is used as an index into a table of two-bit saturating counters. The upper bit of the selected counter is the guess. That guess is registered together with the fetch address, so it travels with the instruction into decode. The table keeps no tags, so two branches whose index bits are equal share a counter. Aliasing of this kind can cost accuracy, but it never makes the result wrong.

Decode resolves the branch and then reports three things on the update port: the address of the branch, the guess that travelled with it, and the real outcome. In the same cycle the block flags a misprediction, so the pipeline can squash the wrong-path instruction and refetch on the correct path. On the next clock edge the block moves the counter one step toward the outcome.

The fetch side is a valid/ready stream. A fetch is taken on a clock edge when `fetch_valid` and `fetch_ready` are both high. The prediction output holds its beat until `pred_valid` and `pred_ready` are both high at an edge. While the beat is held, `fetch_ready` is low and the held values do not change. The update port has no back-pressure: every cycle with `upd_valid` high is consumed.

Top module: `branch_hist_table`

## Requirements
- R1: After reset, `pred_valid` is 0 and `fetch_ready` is 1. Every counter starts at 01 (weak not-taken), so the first guess for any address is not-taken, and one taken update turns it to taken.
- R2: The index is `pc[OFS_W +: IDX_W]` (bits 13:2 by default, 4096 counters). Addresses that differ only in bits 1:0, or only above bit 13, share one counter. Addresses that differ in bits 13:2 use separate counters.
- R3: Counter encoding is 11 strong taken, 10 weak taken, 01 weak not-taken, 00 strong not-taken. The guess is bit 1.
- R4: A taken update adds one, saturating at 11. A not-taken update subtracts one, saturating at 00.
- R5: From a strong state, two wrong outcomes in a row are needed before the guess changes direction.
- R6: A fetch taken at an edge appears after that edge with `pred_valid` = 1, `pred_pc` equal to the fetch address, and the guess read at that edge. If no new fetch is taken, the beat leaves once it is accepted.
- R7: While `pred_valid` is 1 and `pred_ready` is 0, `fetch_ready` is 0 and `pred_pc` and `pred_taken` stay unchanged, even if the counter behind them is updated meanwhile.
- R8: When a fetch and an update hit the same counter at the same edge, the fetch sees the value from before the update.
- R9: `mispredict` is high in the same cycle exactly when `upd_valid` is 1 and `upd_pred_taken` differs from `upd_taken`. It is 0 whenever `upd_valid` is 0.
- R10: For a loop branch taken nine times and then not taken once, each pass of the loop after the first has exactly one misprediction.
- R11: While `upd_valid` is 0, the values on the other update inputs leave every counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch address is offered |
| fetch_ready | output | 1 | The block can take a fetch at this edge |
| fetch_pc | input | PC_W | Fetch address |
| pred_valid | output | 1 | A prediction beat is present |
| pred_ready | input | 1 | Decode accepts the prediction beat |
| pred_pc | output | PC_W | Address the beat belongs to |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is reported |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_pred_taken | input | 1 | Guess that travelled with the branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| mispredict | output | 1 | Guess and outcome differ; flush and redirect |

## Verification
The properties assume that `fetch_pc` is held steady only while a fetch is offered, and that decode reports each resolution once, in the cycle it is decided. The properties take no position on counter contents. Those are left to the bench's reference table, which replays every update in the order the edges apply them. Stimulus changes inputs only a moment after the rising edge. A random phase stays inside a handful of addresses, some of them aliased, so that counters saturate and collide.

// File: rtl/bht_pkg.sv
package bht_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  localparam ctr_e CTR_INIT = CTR_WNT;

  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_ST) nxt = ctr_e'(cur + 2'd1);
    end else begin
      if (cur != CTR_SNT) nxt = ctr_e'(cur - 2'd1);
    end
    return nxt;
  endfunction

  function automatic logic ctr_guess(input ctr_e cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
  parameter int PC_W  = 32,
  parameter int OFS_W = 2,
  parameter int IDX_W = 12
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  logic unused_pc_bits;
  assign idx = pc[OFS_W +: IDX_W];
  assign unused_pc_bits = ^pc;
endmodule

// File: rtl/bht_table.sv
module bht_table
  import bht_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_e             rd_state,
  input  logic [IDX_W-1:0] wr_idx,
  output ctr_e             wr_cur,
  input  logic             wr_en,
  input  ctr_e             wr_state
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_e mem [DEPTH];

  assign rd_state = mem[rd_idx];
  assign wr_cur   = mem[wr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_state;
    end
  end
endmodule

// File: rtl/bht_resolve.sv
module bht_resolve
  import bht_pkg::*;
(
  input  logic upd_valid,
  input  logic upd_pred_taken,
  input  logic upd_taken,
  input  ctr_e cur_state,
  output ctr_e nxt_state,
  output logic wr_en,
  output logic mispredict
);
  assign nxt_state  = ctr_step(cur_state, upd_taken);
  assign wr_en      = upd_valid;
  assign mispredict = upd_valid & (upd_pred_taken ^ upd_taken);
endmodule

// File: rtl/bht_pred_reg.sv
module bht_pred_reg #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PC_W-1:0] in_pc,
  input  logic            in_taken,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PC_W-1:0] out_pc,
  output logic            out_taken
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pc    <= '0;
      out_taken <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_pc    <= in_pc;
      out_taken <= in_taken;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/branch_hist_table.sv
module branch_hist_table
  import bht_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int OFS_W = 2,
  parameter int IDX_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  output logic            fetch_ready,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_valid,
  input  logic            pred_ready,
  output logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_pred_taken,
  input  logic            upd_taken,
  output logic            mispredict
);
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  ctr_e             rd_state;
  ctr_e             wr_cur;
  ctr_e             wr_state;
  logic             wr_en;
  logic             rd_guess;

  bht_index #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) fetch_idx_i (
    .pc (fetch_pc),
    .idx(rd_idx)
  );

  bht_index #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) upd_idx_i (
    .pc (upd_pc),
    .idx(wr_idx)
  );

  bht_table #(.IDX_W(IDX_W)) table_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rd_idx),
    .rd_state(rd_state),
    .wr_idx  (wr_idx),
    .wr_cur  (wr_cur),
    .wr_en   (wr_en),
    .wr_state(wr_state)
  );

  bht_resolve resolve_i (
    .upd_valid     (upd_valid),
    .upd_pred_taken(upd_pred_taken),
    .upd_taken     (upd_taken),
    .cur_state     (wr_cur),
    .nxt_state     (wr_state),
    .wr_en         (wr_en),
    .mispredict    (mispredict)
  );

  assign rd_guess = ctr_guess(rd_state);

  bht_pred_reg #(.PC_W(PC_W)) pred_reg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (fetch_valid),
    .in_ready (fetch_ready),
    .in_pc    (fetch_pc),
    .in_taken (rd_guess),
    .out_valid(pred_valid),
    .out_ready(pred_ready),
    .out_pc   (pred_pc),
    .out_taken(pred_taken)
  );
endmodule

// File: rtl/bht_checker.sv
module bht_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_valid,
  input logic            fetch_ready,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_valid,
  input logic            pred_ready,
  input logic [PC_W-1:0] pred_pc,
  input logic            pred_taken,
  input logic            upd_valid,
  input logic            upd_pred_taken,
  input logic            upd_taken,
  input logic            mispredict
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && !pred_ready |=> pred_valid && $stable(pred_pc) && $stable(pred_taken));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready |=> pred_valid && (pred_pc == $past(fetch_pc)));

  assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && pred_ready && !fetch_valid |=> !pred_valid);

  assert_empty_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |-> fetch_ready);

  assert_quiet_mis_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> !mispredict);

  assert_agree_mis_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && (upd_pred_taken == upd_taken) |-> !mispredict);
endmodule

bind branch_hist_table bht_checker #(.PC_W(PC_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_valid   (fetch_valid),
  .fetch_ready   (fetch_ready),
  .fetch_pc      (fetch_pc),
  .pred_valid    (pred_valid),
  .pred_ready    (pred_ready),
  .pred_pc       (pred_pc),
  .pred_taken    (pred_taken),
  .upd_valid     (upd_valid),
  .upd_pred_taken(upd_pred_taken),
  .upd_taken     (upd_taken),
  .mispredict    (mispredict)
);

// File: tb/branch_hist_table_tb_top.sv
module branch_hist_table_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 32;
  localparam int OFS_W = 2;
  localparam int IDX_W = 12;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n;
  logic fetch_valid, fetch_ready;
  logic [PC_W-1:0] fetch_pc;
  logic pred_valid, pred_ready, pred_taken;
  logic [PC_W-1:0] pred_pc;
  logic upd_valid, upd_pred_taken, upd_taken, mispredict;
  logic [PC_W-1:0] upd_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_hist_table #(.PC_W(PC_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_pc(pred_pc),
    .pred_taken(pred_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_pred_taken(upd_pred_taken),
    .upd_taken(upd_taken), .mispredict(mispredict)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  bit [1:0] ref_tbl [DEPTH];

  typedef struct packed {
    logic [PC_W-1:0] pc;
    logic            tk;
  } exp_t;
  exp_t sb_q[$];

  function automatic int idx_of(input logic [PC_W-1:0] pc);
    return int'(pc[OFS_W +: IDX_W]);
  endfunction

  function automatic bit [1:0] ref_next(input bit [1:0] s, input bit tk);
    if (tk) return (s == 2'b11) ? s : s + 2'd1;
    return (s == 2'b00) ? s : s - 2'd1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected beat per accepted prediction
  always @(negedge clk) begin
    if (rst_n === 1'b1 && pred_valid && pred_ready) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R6 beat with no fetch", {31'd0, pred_pc, pred_taken}, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(pred_pc == e.pc && pred_taken == e.tk, "R4 scoreboard beat",
            {31'd0, pred_pc, pred_taken}, {31'd0, e.pc, e.tk});
      end
    end
  end

  // one clock: drive just after a rising edge, judge at the falling edge
  task automatic step(input bit fv, input logic [PC_W-1:0] fpc, input bit uv,
                      input logic [PC_W-1:0] upc, input bit upred, input bit utk,
                      input bit prdy, output bit acc, output bit mis);
    exp_t e;
    fetch_valid = fv; fetch_pc = fpc;
    upd_valid = uv; upd_pc = upc; upd_pred_taken = upred; upd_taken = utk;
    pred_ready = prdy;
    @(negedge clk);
    acc = fv && fetch_ready;
    mis = mispredict;
    if (acc) begin
      e.pc = fpc;
      e.tk = ref_tbl[idx_of(fpc)][1];
      sb_q.push_back(e);
    end
    chk(mispredict == (uv && (upred != utk)), "R9 mispredict flag",
        {63'd0, mispredict}, {63'd0, uv && (upred != utk)});
    if (uv) ref_tbl[idx_of(upc)] = ref_next(ref_tbl[idx_of(upc)], utk);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input bit prdy);
    bit a, m;
    step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, prdy, a, m);
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input bit tk);
    bit a, m;
    step(1'b0, '0, 1'b1, pc, 1'b0, tk, 1'b1, a, m);
  endtask

  task automatic probe(input logic [PC_W-1:0] pc, input bit exp, input string tag);
    bit a, m;
    step(1'b1, pc, 1'b0, '0, 1'b0, 1'b0, 1'b1, a, m);
    fetch_valid = 1'b0; upd_valid = 1'b0; pred_ready = 1'b1;
    @(negedge clk);
    chk(pred_valid && pred_pc == pc && pred_taken == exp, tag,
        {31'd0, pred_pc, pred_taken}, {31'd0, pc, exp});
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit a, m;
    int mis_cnt;
    bit p;
    logic [PC_W-1:0] pa, pb, pc_x;
    for (int i = 0; i < DEPTH; i++) ref_tbl[i] = 2'b01;
    rst_n = 1'b0;
    fetch_valid = 0; fetch_pc = '0; pred_ready = 0;
    upd_valid = 0; upd_pc = '0; upd_pred_taken = 0; upd_taken = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!pred_valid && fetch_ready, "R1 reset outputs",
        {62'd0, pred_valid, fetch_ready}, 64'd1);
    @(posedge clk); #1;

    // R1 / R3: initial weak not-taken, one taken flips guess
    pa = 32'h0000_0040;
    probe(pa, 1'b0, "R1 first guess not taken");
    upd(pa, 1'b1);
    probe(pa, 1'b1, "R3 weak taken guess");

    // R4 / R5: saturate high, then two wrongs to flip
    repeat (3) upd(pa, 1'b1);
    upd(pa, 1'b0);
    probe(pa, 1'b1, "R5 one miss keeps strong taken");
    upd(pa, 1'b0);
    probe(pa, 1'b0, "R5 second miss flips");
    repeat (5) upd(pa, 1'b0);
    upd(pa, 1'b1);
    probe(pa, 1'b0, "R4 saturated low then one taken");
    upd(pa, 1'b1);
    probe(pa, 1'b1, "R4 second taken");

    // R2: aliasing and distinct entries
    pb = 32'h0000_0080;
    pc_x = pb + (32'h1 << (OFS_W + IDX_W));
    upd(pc_x, 1'b1);
    probe(pb, 1'b1, "R2 high bits alias");
    probe(pb + 32'd3, 1'b1, "R2 byte offset alias");
    probe(pb + 32'd4, 1'b0, "R2 neighbour separate");

    // R8: same-edge read and update
    pc_x = 32'h0000_0200;
    step(1'b1, pc_x, 1'b1, pc_x, 1'b0, 1'b1, 1'b1, a, m);
    fetch_valid = 0; upd_valid = 0;
    @(negedge clk);
    chk(pred_valid && pred_taken == 1'b0, "R8 read sees old value",
        {63'd0, pred_taken}, 64'd0);
    @(posedge clk); #1;
    probe(pc_x, 1'b1, "R8 update landed");

    // R7: back-pressure holds beat
    pc_x = 32'h0000_0300;
    step(1'b1, pc_x, 1'b0, '0, 1'b0, 1'b0, 1'b0, a, m);
    chk(a, "R7 empty stage takes fetch", {63'd0, a}, 64'd1);
    step(1'b1, 32'h0000_0304, 1'b1, pc_x, 1'b0, 1'b1, 1'b0, a, m);
    chk(!a, "R7 fetch_ready low while stalled", {63'd0, a}, 64'd0);
    step(1'b0, '0, 1'b1, pc_x, 1'b0, 1'b1, 1'b0, a, m);
    chk(pred_valid && pred_pc == pc_x && pred_taken == 1'b0, "R7 held beat unchanged",
        {31'd0, pred_pc, pred_taken}, {31'd0, pc_x, 1'b0});
    idle(1'b1);
    probe(pc_x, 1'b1, "R7 updates during stall applied");

    // R11: invalid update ignored
    pc_x = 32'h0000_0400;
    repeat (3) step(1'b0, '0, 1'b0, pc_x, 1'b0, 1'b1, 1'b1, a, m);
    probe(pc_x, 1'b0, "R11 no write without valid");

    // R10: loop branch taken nine times then not taken
    pc_x = 32'h0000_0500;
    for (int pass = 0; pass < 3; pass++) begin
      mis_cnt = 0;
      for (int it = 0; it < 10; it++) begin
        p = ref_tbl[idx_of(pc_x)][1];
        step(1'b1, pc_x, 1'b0, '0, 1'b0, 1'b0, 1'b1, a, m);
        step(1'b0, '0, 1'b1, pc_x, p, (it < 9), 1'b1, a, m);
        if (m) mis_cnt++;
      end
      if (pass > 0)
        chk(mis_cnt == 1, "R10 one miss per loop pass", 64'(mis_cnt), 64'd1);
    end

    // random mix with aliasing and stalls
    for (int k = 0; k < 400; k++) begin
      logic [PC_W-1:0] rf, ru;
      rf = 32'h1000 + 32'(($urandom % 4) * 4) + 32'(($urandom % 2) << (OFS_W + IDX_W));
      ru = 32'h1000 + 32'(($urandom % 4) * 4) + 32'(($urandom % 2) << (OFS_W + IDX_W));
      step(bit'($urandom % 2), rf, bit'($urandom % 2), ru, bit'($urandom % 2),
           bit'($urandom % 2), ($urandom % 4) != 0, a, m);
    end
    repeat (3) idle(1'b1);
    chk(sb_q.size() == 0, "R6 every fetch produced a beat", 64'(sb_q.size()), 64'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule